// File: doc/BRIEF.md
# Deflection Adjustment Register Target (I2C)

This block is the serial control port of a display deflection controller. A host on a two-wire I2C bus writes the controller's analog adjustment settings and its individual control flags into a small register bank. The same host can read back one status byte that reports lock, polarity, protection and sync-detection conditions. The bank drives the deflection circuitry directly as flat parallel buses.

A write names a starting subaddress and then streams any number of data bytes. Each byte lands one register above the previous one, so the whole bank can be reloaded in a single burst. A read needs no subaddress and returns the status byte. Both bus lines pass through digital glitch filters before any decoding. SDA is driven only through an open-drain pull-down enable. A supply-good input clears the bank and silences the bus driver whenever the logic supply is not valid.

Top module: `defl_i2c_adj_regs`

## Requirements
- R1: The block answers only the 7-bit device address 0x46 (address byte 0x8C to write, 0x8D to read). Any other address gets no ACK, and SDA stays undriven until the next START.
- R2: In a write, the first byte after the address is the subaddress, and the byte after it is stored in the register at that subaddress.
- R3: Each further data byte, with no STOP or repeated START in between, is stored at the previous subaddress plus one. The counter is 8 bits wide and wraps.
- R4: Data bytes aimed at subaddresses 17 and above are ACKed but change no register.
- R5: A read returns one byte, most significant bit first: [7] horizontal lock, [6] vertical lock, [5] X-ray trip, [4] horizontal polarity, [3] vertical polarity, [2:0] sync-detect code. The byte is sampled when the address ACK begins.
- R6: After the eighth bit of the status byte, SDA is released whatever the host answers, and it stays released for any further clocks until a new START.
- R7: A STOP ends the transaction and releases SDA. A repeated START begins a fresh address phase.
- R8: A level change on SCL or SDA that lasts fewer than FILT_CYCLES system clocks (default 16, which is 64 ns at 250 MHz) is ignored.
- R9: While supply_ok is low, every register holds its default value, SDA is not driven, and any transaction in progress is abandoned. Bytes that follow before a new START are NACKed.
- R10: After reset, subaddresses 0 to 13 hold 0x80 and subaddresses 14 to 16 hold 0x00.
- R11: The 17 control flags live at subaddresses 14 (ctrl_bits[7:0]), 15 (ctrl_bits[15:8]) and 16 (ctrl_bits[16] = data bit 0). Bits 7:1 written to subaddress 16 are dropped. Subaddress n below 14 drives adj_bus[8n+7:8n].
- R12: The block pulls SDA low during the ninth clock of its matching address byte and of every written byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Logic supply valid; low clears the bank and gates SDA |
| scl_in | input | 1 | Serial clock level from the pad |
| sda_in | input | 1 | Serial data level from the pad |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| st_hlock | input | 1 | Horizontal PLL locked |
| st_vlock | input | 1 | Vertical sync locked |
| st_xray | input | 1 | X-ray protection tripped |
| st_hpol | input | 1 | Detected horizontal sync polarity |
| st_vpol | input | 1 | Detected vertical sync polarity |
| st_sync | input | 3 | Sync-detection code |
| adj_bus | output | 112 | Fourteen adjustment bytes, subaddress 0 in the low byte |
| ctrl_bits | output | 17 | Control flags from subaddresses 14 to 16 |

## Verification
The bound checker watches five things on every cycle:
- consecutive stores within one transaction rise by exactly one subaddress;
- stores to unmapped subaddresses leave both output buses untouched;
- SDA is only ever taken low while the filtered SCL is low;
- START and STOP both release SDA;
- a cycle with supply_ok low is followed by default contents and an idle driver.

Address filtering, the bit order of the status byte and the moment it is sampled, the lengths of rejected glitches, and the NACK of bytes after a supply dropout can only be shown by the bench's bus transactions.

// File: rtl/defl_i2c_pkg.sv
package defl_i2c_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX
  } tgt_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_SUB,
    K_DATA
  } byte_kind_e;

  // Reset value of a register: adjustments sit at mid-scale, flags off.
  function automatic logic [7:0] reg_default(int unsigned idx, int unsigned n_adj);
    return (idx < n_adj) ? 8'h80 : 8'h00;
  endfunction

  // Number of stored bits in register idx (only the last flag register is partial).
  function automatic int unsigned reg_width(int unsigned idx, int unsigned n_adj,
                                            int unsigned n_ctrl_bits);
    int unsigned lo;
    if (idx < n_adj) return 8;
    lo = (idx - n_adj) * 8;
    if (n_ctrl_bits >= lo + 8) return 8;
    return n_ctrl_bits - lo;
  endfunction

  // Status reply layout, MSB first on the wire.
  function automatic logic [7:0] pack_status(logic hlock, logic vlock, logic xray,
                                             logic hpol, logic vpol, logic [2:0] sync);
    return {hlock, vlock, xray, hpol, vpol, sync};
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned FILT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);

  logic [1:0]    sync_q;
  logic          filt_q;
  logic [CW-1:0] cnt_q;
  logic          differs;

  assign differs = sync_q[1] != filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (!differs) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
        filt_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign line_o = filt_q;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import defl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h46
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [7:0] status_i,
  output logic       sda_oe_o,
  output logic       start_o,
  output logic       stop_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  tgt_state_e state_q;
  byte_kind_e kind_q;
  logic       scl_q, sda_q;
  logic [3:0] bitcnt_q;
  logic [7:0] shreg_q, txsh_q, ptr_q;
  logic       rd_q, oe_q;
  logic       scl_rise, scl_fall, addr_hit, byte_done;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_o   = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_o    = scl_f & scl_q & ~sda_q & sda_f;
  assign addr_hit  = shreg_q[7:1] == DEV_ADDR;
  assign byte_done = scl_fall && (bitcnt_q == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      kind_q    <= K_ADDR;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      txsh_q    <= '0;
      ptr_q     <= '0;
      rd_q      <= 1'b0;
      oe_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (clr) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_o) begin
        state_q  <= ST_RX;
        kind_q   <= K_ADDR;
        bitcnt_q <= '0;
        oe_q     <= 1'b0;
      end else if (stop_o) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise && bitcnt_q != 4'd8) begin
              shreg_q  <= {shreg_q[6:0], sda_f};
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (byte_done) begin
              bitcnt_q <= '0;
              unique case (kind_q)
                K_ADDR: begin
                  if (addr_hit) begin
                    oe_q    <= 1'b1;
                    state_q <= ST_RX_ACK;
                    rd_q    <= shreg_q[0];
                    txsh_q  <= status_i;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                K_SUB: begin
                  ptr_q   <= shreg_q;
                  oe_q    <= 1'b1;
                  state_q <= ST_RX_ACK;
                end
                default: begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr_q;
                  wr_data_o <= shreg_q;
                  ptr_q     <= ptr_q + 8'd1;
                  oe_q      <= 1'b1;
                  state_q   <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              if (kind_q == K_ADDR && rd_q) begin
                state_q  <= ST_TX;
                oe_q     <= ~txsh_q[7];
                bitcnt_q <= '0;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_RX;
                kind_q  <= (kind_q == K_ADDR) ? K_SUB : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (byte_done) begin
              oe_q    <= 1'b0;
              state_q <= ST_IDLE;
            end else if (scl_fall) begin
              txsh_q <= {txsh_q[6:0], 1'b0};
              oe_q   <= ~txsh_q[6];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/defl_adj_regfile.sv
module defl_adj_regfile
  import defl_i2c_pkg::*;
#(
  parameter int unsigned NUM_ADJ       = 14,
  parameter int unsigned NUM_CTRL_BITS = 17,
  parameter int unsigned NUM_REGS      = 17
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_addr,
  input  logic [7:0]                 wr_data,
  output logic [NUM_ADJ*8-1:0]       adj_o,
  output logic [NUM_CTRL_BITS-1:0]   ctrl_o
);
  localparam int unsigned TOTAL_BITS = NUM_ADJ * 8 + NUM_CTRL_BITS;

  logic [TOTAL_BITS-1:0] store_flat;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam int unsigned W   = reg_width(i, NUM_ADJ, NUM_CTRL_BITS);
    localparam logic [7:0]  DEF = reg_default(i, NUM_ADJ);
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= DEF[W-1:0];
      else if (clr)                             q <= DEF[W-1:0];
      else if (wr_en && wr_addr == 8'(i))       q <= wr_data[W-1:0];
    end
    assign store_flat[i*8 +: W] = q;
  end

  assign adj_o  = store_flat[0 +: NUM_ADJ*8];
  assign ctrl_o = store_flat[NUM_ADJ*8 +: NUM_CTRL_BITS];
endmodule

// File: rtl/defl_i2c_adj_regs.sv
module defl_i2c_adj_regs
  import defl_i2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR      = 7'h46,
  parameter int unsigned NUM_ADJ       = 14,
  parameter int unsigned NUM_CTRL_BITS = 17,
  parameter int unsigned FILT_CYCLES   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     supply_ok,
  input  logic                     scl_in,
  input  logic                     sda_in,
  output logic                     sda_oe,
  input  logic                     st_hlock,
  input  logic                     st_vlock,
  input  logic                     st_xray,
  input  logic                     st_hpol,
  input  logic                     st_vpol,
  input  logic [2:0]               st_sync,
  output logic [NUM_ADJ*8-1:0]     adj_bus,
  output logic [NUM_CTRL_BITS-1:0] ctrl_bits
);
  localparam int unsigned NUM_CTRL_REGS = (NUM_CTRL_BITS + 7) / 8;
  localparam int unsigned NUM_REGS      = NUM_ADJ + NUM_CTRL_REGS;

  logic [1:0] raw_lines, filt_lines;
  logic       scl_f, sda_f;
  logic       start_det, stop_det;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data;
  logic       sda_oe_raw;
  logic [7:0] status_byte;
  logic       clr;

  assign raw_lines = {sda_in, scl_in};
  for (genvar k = 0; k < 2; k++) begin : g_filt
    i2c_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[k]),
      .line_o (filt_lines[k])
    );
  end
  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  assign clr         = ~supply_ok;
  assign status_byte = pack_status(st_hlock, st_vlock, st_xray, st_hpol, st_vpol, st_sync);

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .status_i  (status_byte),
    .sda_oe_o  (sda_oe_raw),
    .start_o   (start_det),
    .stop_o    (stop_det),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  defl_adj_regfile #(
    .NUM_ADJ       (NUM_ADJ),
    .NUM_CTRL_BITS (NUM_CTRL_BITS),
    .NUM_REGS      (NUM_REGS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .adj_o   (adj_bus),
    .ctrl_o  (ctrl_bits)
  );

  assign sda_oe = sda_oe_raw & supply_ok;
endmodule

// File: rtl/defl_i2c_adj_regs_chk.sv
module defl_i2c_adj_regs_chk #(
  parameter int unsigned NUM_ADJ       = 14,
  parameter int unsigned NUM_CTRL_BITS = 17,
  parameter int unsigned NUM_REGS      = 17
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     supply_ok,
  input logic                     scl_f,
  input logic                     sda_oe_raw,
  input logic                     sda_oe,
  input logic                     start_det,
  input logic                     stop_det,
  input logic                     wr_en,
  input logic [7:0]               wr_addr,
  input logic [NUM_ADJ*8-1:0]     adj_bus,
  input logic [NUM_CTRL_BITS-1:0] ctrl_bits
);
  localparam logic [NUM_ADJ*8-1:0] DEF_ADJ = {NUM_ADJ{8'h80}};

  logic       have_prev;
  logic [7:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (start_det || !supply_ok) begin
      have_prev <= 1'b0;
    end else if (wr_en) begin
      have_prev <= 1'b1;
      prev_addr <= wr_addr;
    end
  end

  // R3
  auto_increment_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && have_prev) |-> (wr_addr == prev_addr + 8'd1));

  // R4
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && supply_ok && wr_addr >= 8'(NUM_REGS)) |=> ($stable(adj_bus) && $stable(ctrl_bits)));

  // R12
  drive_only_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_raw) |-> !scl_f);

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_raw);

  // R7
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe_raw);

  // R9
  supply_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(supply_ok) |-> (adj_bus == DEF_ADJ && ctrl_bits == '0 && !sda_oe));
endmodule

bind defl_i2c_adj_regs defl_i2c_adj_regs_chk #(
  .NUM_ADJ       (NUM_ADJ),
  .NUM_CTRL_BITS (NUM_CTRL_BITS),
  .NUM_REGS      (NUM_REGS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_ok  (supply_ok),
  .scl_f      (scl_f),
  .sda_oe_raw (sda_oe_raw),
  .sda_oe     (sda_oe),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .adj_bus    (adj_bus),
  .ctrl_bits  (ctrl_bits)
);

// File: tb/tb_defl_i2c_adj_regs.sv
module tb_defl_i2c_adj_regs;
  localparam int Q             = 32;
  localparam int FILT          = 16;
  localparam int NUM_ADJ       = 14;
  localparam int NUM_CTRL_BITS = 17;
  localparam int NUM_REGS      = 17;
  localparam int CTRL_PAD      = 24;
  localparam logic [7:0] WADDR = 8'h8C;
  localparam logic [7:0] RADDR = 8'h8D;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, supply_ok, scl_m, sda_m;
  logic st_hlock, st_vlock, st_xray, st_hpol, st_vpol;
  logic [2:0] st_sync;
  logic sda_oe;
  logic [NUM_ADJ*8-1:0] adj_bus;
  logic [NUM_CTRL_BITS-1:0] ctrl_bits;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  defl_i2c_adj_regs dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .st_hlock(st_hlock), .st_vlock(st_vlock), .st_xray(st_xray),
    .st_hpol(st_hpol), .st_vpol(st_vpol), .st_sync(st_sync),
    .adj_bus(adj_bus), .ctrl_bits(ctrl_bits)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_regs [NUM_REGS];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] wmask(input int i);
    int left;
    if (i < NUM_ADJ) return 8'hFF;
    left = NUM_CTRL_BITS - (i - NUM_ADJ) * 8;
    if (left >= 8) return 8'hFF;
    return 8'((1 << left) - 1);
  endfunction

  function automatic logic [7:0] act_reg(input int i);
    logic [CTRL_PAD-1:0] pad;
    pad = {{(CTRL_PAD-NUM_CTRL_BITS){1'b0}}, ctrl_bits};
    if (i < NUM_ADJ) return adj_bus[i*8 +: 8];
    return pad[(i-NUM_ADJ)*8 +: 8];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NUM_REGS; i++) exp_regs[i] = (i < NUM_ADJ) ? 8'h80 : 8'h00;
  endtask

  task automatic model_write(input int sub, input logic [7:0] d);
    if (sub < NUM_REGS) exp_regs[sub] = d & wmask(sub);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NUM_REGS; i++)
      chk(act_reg(i) == exp_regs[i], req, $sformatf("reg %0d", i), 32'(act_reg(i)), 32'(exp_regs[i]));
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic bit_out(input logic b, input bit glitch);
    sda_m = b; tick(Q); scl_m = 1'b1;
    if (glitch) begin
      tick(Q/2); sda_m = ~b; tick(FILT-6); sda_m = b; tick(2*Q - Q/2 - (FILT-6));
    end else begin
      tick(2*Q);
    end
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic byte_out(input logic [7:0] d, input int glitch_bit, output bit ack);
    for (int i = 7; i >= 0; i--) bit_out(d[i], i == glitch_bit);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = (sda_bus == 1'b0);
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic byte_in(input bit host_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); d[i] = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = host_ack ? 1'b0 : 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic glitch_scl();
    tick(Q); scl_m = 1'b1; tick(FILT-6); scl_m = 1'b0; tick(Q);
  endtask

  task automatic set_status(input logic [7:0] s);
    {st_hlock, st_vlock, st_xray, st_hpol, st_vpol, st_sync} = s;
  endtask

  task automatic write_one(input int sub, input logic [7:0] d, input string req);
    bit ack;
    bus_start();
    byte_out(WADDR, -1, ack); chk(ack, "R12", "address ack", 32'(ack), 1);
    byte_out(8'(sub), -1, ack); chk(ack, "R12", "subaddress ack", 32'(ack), 1);
    byte_out(d, -1, ack); chk(ack, req, "data ack", 32'(ack), 1);
    bus_stop();
    model_write(sub, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rd, sa, sb;
    rst_n = 1'b0; supply_ok = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    set_status(8'h00);
    model_reset();
    tick(20);
    rst_n = 1'b1;
    tick(10);

    // R10: reset values
    check_regs("R10");
    chk(sda_oe == 1'b0, "R10", "sda idle", 32'(sda_oe), 0);

    // R2: single write
    write_one(3, 8'h5A, "R2");
    check_regs("R2");

    // R3 + R4: burst over the whole bank and two unmapped subaddresses
    bus_start();
    byte_out(WADDR, -1, ack); chk(ack, "R12", "address ack", 32'(ack), 1);
    byte_out(8'h00, -1, ack); chk(ack, "R12", "subaddress ack", 32'(ack), 1);
    for (int i = 0; i < NUM_REGS + 2; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 11);
      byte_out(v, -1, ack);
      chk(ack, (i < NUM_REGS) ? "R3" : "R4", $sformatf("burst ack %0d", i), 32'(ack), 1);
      model_write(i, v);
    end
    bus_stop();
    check_regs("R3");

    // R11: partial flag register and full flag byte
    write_one(16, 8'hFF, "R11");
    write_one(14, 8'hA5, "R11");
    chk(ctrl_bits[16] == 1'b1, "R11", "flag 16", 32'(ctrl_bits[16]), 1);
    chk(ctrl_bits[7:0] == 8'hA5, "R11", "flags 7:0", 32'(ctrl_bits[7:0]), 32'hA5);
    check_regs("R11");

    // R4: unmapped single write
    write_one(8'h20, 8'h33, "R4");
    check_regs("R4");

    // R1: foreign address
    bus_start();
    byte_out(8'h8E, -1, ack); chk(!ack, "R1", "foreign address nack", 32'(ack), 0);
    byte_out(8'h02, -1, ack); chk(!ack, "R1", "byte after foreign address", 32'(ack), 0);
    byte_out(8'h77, -1, ack); chk(!ack, "R1", "second byte after foreign", 32'(ack), 0);
    bus_stop();
    check_regs("R1");

    // R7: repeated start restarts the address phase
    bus_start();
    byte_out(WADDR, -1, ack);
    byte_out(8'd5, -1, ack);
    byte_out(8'h11, -1, ack); model_write(5, 8'h11);
    bus_start();
    byte_out(WADDR, -1, ack); chk(ack, "R7", "address after restart", 32'(ack), 1);
    byte_out(8'd9, -1, ack);
    byte_out(8'h22, -1, ack); model_write(9, 8'h22);
    bus_stop();
    chk(sda_oe == 1'b0, "R7", "released after stop", 32'(sda_oe), 0);
    check_regs("R7");

    // R5: status sweep with host NACK
    for (int k = 0; k < 10; k++) begin
      sa = 8'(k * 53 + 7);
      set_status(sa);
      bus_start();
      byte_out(RADDR, -1, ack); chk(ack, "R12", "read address ack", 32'(ack), 1);
      byte_in(1'b0, rd);
      bus_stop();
      chk(rd == sa, "R5", $sformatf("status %0d", k), 32'(rd), 32'(sa));
    end

    // R5: value captured at address ack
    sa = 8'hC6; sb = 8'h39;
    set_status(sa);
    bus_start();
    byte_out(RADDR, -1, ack);
    set_status(sb);
    byte_in(1'b0, rd);
    bus_stop();
    chk(rd == sa, "R5", "capture point", 32'(rd), 32'(sa));

    // R6: host ACK, then more clocks: block stays released
    set_status(8'h00);
    bus_start();
    byte_out(RADDR, -1, ack);
    byte_in(1'b1, rd);
    chk(rd == 8'h00, "R6", "reply", 32'(rd), 0);
    byte_in(1'b0, rd);
    chk(rd == 8'hFF, "R6", "extra byte released", 32'(rd), 32'hFF);
    bus_stop();

    // R8: short pulses on both lines inside a write
    bus_start();
    byte_out(WADDR, -1, ack);
    byte_out(8'd7, -1, ack);
    glitch_scl();
    byte_out(8'hB7, 7, ack); chk(ack, "R8", "data ack with glitches", 32'(ack), 1);
    model_write(7, 8'hB7);
    glitch_scl();
    bus_stop();
    check_regs("R8");

    // R9: supply dropout in the middle of a write
    bus_start();
    byte_out(WADDR, -1, ack);
    byte_out(8'd2, -1, ack);
    supply_ok = 1'b0;
    tick(5);
    model_reset();
    check_regs("R9");
    chk(sda_oe == 1'b0, "R9", "sda gated", 32'(sda_oe), 0);
    supply_ok = 1'b1;
    tick(3);
    byte_out(8'h44, -1, ack); chk(!ack, "R9", "byte after dropout nack", 32'(ack), 0);
    bus_stop();
    check_regs("R9");

    // R2 after recovery: block works again
    write_one(0, 8'h3C, "R2");
    check_regs("R2");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule